// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generator/Checker

This block joins two data buses, side A and side B, through a direction-controlled transceiver. When the direction input selects transmit, side A data is driven onto side B. When it selects receive, side B data is driven onto side A. An active-low enable releases both sides at once. Each bidirectional pin is modelled as a separate input, output and output-enable signal, so the pads can sit outside the block.

A parity stage shares the data path. In transmit it computes a parity bit from side A and drives it on the parity pin. In receive that pin becomes an input. The block then checks it against side B data and pulls an active-low error flag when the two disagree. A select input picks even or odd parity, and the same setting applies to generation and to checking.

All outputs are registered on the clock. Each output therefore reflects the inputs sampled at the previous rising edge. A synchronous active-high reset puts the block into the released, error-free state.

Top module: `xcvr_parity`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `a_oe`=0, `b_oe`=0, `par_oe`=0, `err_n`=1, `a_out`=0, `b_out`=0 and `par_out`=0.
- R2: With `oe_n`=0 and `dir_tx`=1 (transmit), the next cycle has `b_oe`=1, `a_oe`=0, and `b_out` equal to `a_in`.
- R3: With `oe_n`=0 and `dir_tx`=0 (receive), the next cycle has `a_oe`=1, `b_oe`=0, and `a_out` equal to `b_in`.
- R4: With `oe_n`=1, the next cycle has `a_oe`, `b_oe` and `par_oe` all 0, whatever the direction.
- R5: `par_oe` is 1 in the next cycle exactly when `oe_n`=0 and `dir_tx`=1. Otherwise the parity pin is released.
- R6: In transmit with `odd_sel`=0 (even parity), `par_out` is 1 when `a_in` holds an odd number of ones and 0 when it holds an even number.
- R7: In transmit with `odd_sel`=1 (odd parity), `par_out` is the inverse of the even-parity value. The data bits plus `par_out` then hold an odd number of ones.
- R8: In receive, `err_n` goes to 0 exactly when the ones in `b_in` plus `par_in` do not match the parity that was selected. An odd total is an error under even parity (`odd_sel`=0), and an even total is an error under odd parity (`odd_sel`=1).
- R9: In transmit, or while `oe_n`=1, `err_n` is 1 in the next cycle, whatever `par_in` and `b_in` hold.
- R10: Every output changes exactly one clock after the input change that causes it, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Active-low enable for both data sides |
| dir_tx | input | 1 | 1 = A to B (transmit), 0 = B to A (receive) |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_in | input | DATA_W | Side A pad input |
| a_out | output | DATA_W | Side A pad output data |
| a_oe | output | 1 | Side A pad output enable |
| b_in | input | DATA_W | Side B pad input |
| b_out | output | DATA_W | Side B pad output data |
| b_oe | output | 1 | Side B pad output enable |
| par_in | input | 1 | Parity pin input (used in receive) |
| par_out | output | 1 | Parity pin output data (generated in transmit) |
| par_oe | output | 1 | Parity pin output enable |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The hardest case to reach is a receive-mode error under each parity setting. It needs a particular pairing of side B data and the incoming parity bit, and that pairing is the opposite one for odd and for even parity. The stimulus sweeps every 8-bit value on both sides, with both directions, both parity settings and both parity-input levels. A reference count of ones, worked out in the bench, decides for each case whether the flag must fall. A short table of hand-picked vectors comes first and fixes the all-zero, all-one and single-bit patterns. Directed steps then cover reset taken mid-traffic and the released state.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Parity scheme chosen by the select input
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;

  // Number of tree levels needed to reduce a vector of the given width
  function automatic int tree_levels(input int width);
    int lv;
    lv = 0;
    while ((1 << lv) < width) lv++;
    return lv;
  endfunction

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data,
  output logic             odd_ones
);
  import xcvr_pkg::*;

  localparam int LEVELS = tree_levels(WIDTH);
  localparam int LEAVES = 1 << LEVELS;

  // Heap-ordered balanced XOR tree: node 1 is the root, leaves at LEAVES..2*LEAVES-1
  logic [2*LEAVES-1:1] node;

  genvar i, k;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < WIDTH) begin : g_real
        assign node[LEAVES+i] = data[i];
      end else begin : g_pad
        assign node[LEAVES+i] = 1'b0;
      end
    end
    for (k = 1; k < LEAVES; k++) begin : g_node
      assign node[k] = node[2*k] ^ node[2*k+1];
    end
  endgenerate

  assign odd_ones = node[1];

endmodule

// File: rtl/port_steer.sv
module port_steer (
  input  logic oe_n,
  input  logic dir_tx,
  output logic a_drive,
  output logic b_drive,
  output logic rx_check
);
  logic enabled;

  assign enabled  = ~oe_n;
  // Side B and the parity pin are driven together in transmit
  assign b_drive  = enabled &  dir_tx;
  // Side A is driven in receive, which is also when the checker is live
  assign a_drive  = enabled & ~dir_tx;
  assign rx_check = a_drive;

endmodule

// File: rtl/parity_unit.sv
module parity_unit #(
  parameter int DATA_W = 8
) (
  input  logic                [DATA_W-1:0] a_data,
  input  logic                [DATA_W-1:0] b_data,
  input  logic                             par_in,
  input  xcvr_pkg::par_mode_e              mode,
  output logic                             gen_bit,
  output logic                             chk_fail
);
  import xcvr_pkg::*;

  logic a_odd;
  logic b_odd;
  logic want_odd;

  parity_tree #(.WIDTH(DATA_W)) u_tree_a (.data(a_data), .odd_ones(a_odd));
  parity_tree #(.WIDTH(DATA_W)) u_tree_b (.data(b_data), .odd_ones(b_odd));

  assign want_odd = (mode == PAR_ODD);

  // Generated bit makes data plus parity hold the selected total parity
  assign gen_bit  = a_odd ^ want_odd;
  // Received word (data plus incoming bit) must carry the selected total parity
  assign chk_fail = (b_odd ^ par_in) != want_odd;

endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic              dir_tx,
  input  logic              odd_sel,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  output logic              err_n
);
  import xcvr_pkg::*;

  logic a_drive;
  logic b_drive;
  logic rx_check;
  logic gen_bit;
  logic chk_fail;
  par_mode_e mode;

  assign mode = par_mode_e'(odd_sel);

  port_steer u_steer (
    .oe_n     (oe_n),
    .dir_tx   (dir_tx),
    .a_drive  (a_drive),
    .b_drive  (b_drive),
    .rx_check (rx_check)
  );

  parity_unit #(.DATA_W(DATA_W)) u_par (
    .a_data   (a_in),
    .b_data   (b_in),
    .par_in   (par_in),
    .mode     (mode),
    .gen_bit  (gen_bit),
    .chk_fail (chk_fail)
  );

  // Output register stage: one cycle from pins in to pins out
  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe    <= 1'b0;
      b_oe    <= 1'b0;
      par_oe  <= 1'b0;
      a_out   <= '0;
      b_out   <= '0;
      par_out <= 1'b0;
      err_n   <= 1'b1;
    end else begin
      a_oe    <= a_drive;
      b_oe    <= b_drive;
      par_oe  <= b_drive;
      a_out   <= b_in;
      b_out   <= a_in;
      par_out <= gen_bit;
      err_n   <= ~(rx_check & chk_fail);
    end
  end

  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!a_oe && !b_oe && !par_oe));

  // R2 R3
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_oe, b_oe}));

  // R5
  par_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir_tx) |=> par_oe);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_n || dir_tx) |=> err_n);

  // R6 R7
  tx_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir_tx) |=>
      (($countones({b_out, par_out}) % 2) == int'($past(odd_sel))));

  // R8
  rx_check_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir_tx) |=>
      (err_n == (($countones({a_out, $past(par_in)}) % 2) == int'($past(odd_sel)))));

endmodule

// File: tb/xcvr_parity_test.sv
module xcvr_parity_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 12;

  // Vector layout: {oe_n, dir_tx, odd_sel, par_in, a[7:0], b[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0100, 8'h00, 8'h00},
    {4'b0110, 8'h00, 8'h00},
    {4'b0100, 8'hFF, 8'h12},
    {4'b0110, 8'h01, 8'h34},
    {4'b0100, 8'h80, 8'hAA},
    {4'b0001, 8'h5A, 8'h01},
    {4'b0000, 8'h5A, 8'h01},
    {4'b0011, 8'h77, 8'h03},
    {4'b0010, 8'h77, 8'h03},
    {4'b0001, 8'h00, 8'hFF},
    {4'b1100, 8'hC3, 8'h3C},
    {4'b1001, 8'hC3, 8'h3C}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         oe_n, dir_tx, odd_sel, par_in;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_parity #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir_tx(dir_tx), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Drive one input set, wait one full cycle (past the latching edge), compare
  task automatic step(input logic n_oe, input logic tx, input logic odd,
                      input logic pin, input logic [W-1:0] a, input logic [W-1:0] b);
    logic en_tx, en_rx;
    int   rx_tot;
    oe_n = n_oe; dir_tx = tx; odd_sel = odd; par_in = pin; a_in = a; b_in = b;
    @(negedge clk);
    en_tx  = !n_oe && tx;
    en_rx  = !n_oe && !tx;
    rx_tot = ones(b) + int'(pin);
    check(n_oe ? "R4 b_oe" : "R2 b_oe", int'(b_oe), int'(en_tx));
    check(n_oe ? "R4 a_oe" : "R3 a_oe", int'(a_oe), int'(en_rx));
    check("R5 par_oe", int'(par_oe), int'(en_tx));
    if (en_tx) begin
      check("R2 b_out", int'(b_out), int'(a));
      check(odd ? "R7 par_out" : "R6 par_out", int'(par_out),
            (ones(a) % 2) ^ int'(odd));
    end
    if (en_rx) begin
      check("R3 a_out", int'(a_out), int'(b));
      check("R8 err_n", int'(err_n), ((rx_tot % 2) == int'(odd)) ? 1 : 0);
    end else begin
      check("R9 err_n", int'(err_n), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; oe_n = 1'b0; dir_tx = 1'b1; odd_sel = 1'b0; par_in = 1'b1;
    a_in = 8'hFF; b_in = 8'hFF;
    @(negedge clk); @(negedge clk);
    // R1: reset state even with enabling inputs applied
    check("R1 a_oe", int'(a_oe), 0);
    check("R1 b_oe", int'(b_oe), 0);
    check("R1 par_oe", int'(par_oe), 0);
    check("R1 err_n", int'(err_n), 1);
    check("R1 b_out", int'(b_out), 0);
    check("R1 par_out", int'(par_out), 0);
    rst = 1'b0;

    // Table walk
    for (int v = 0; v < NVEC; v++)
      step(VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);

    // Full sweep: every value, both directions, both modes, both parity-pin levels
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++)
          for (int x = 0; x < 256; x++)
            step(1'b0, d[0], m[0], p[0], x[7:0], 8'(x ^ 8'h5C));

    // R10: output holds old value until the latching edge
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 8'h00);
    a_in = 8'h03;
    #1;
    check("R10 par_out before edge", int'(par_out), 1);
    check("R10 b_out before edge", int'(b_out), 8'h01);
    @(negedge clk);
    check("R10 par_out after edge", int'(par_out), 0);

    // R9: a would-be error is masked while disabled, in receive direction
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    // R8: the same pattern flags once enabled
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);

    // R1: reset taken mid-traffic
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid a_oe", int'(a_oe), 0);
    check("R1 mid err_n", int'(err_n), 1);
    check("R1 mid a_out", int'(a_out), 0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule